// File: doc/BRIEF.md
# Interrupt and DMA Sideband Extension for a Shared System Bus

This block supplies the processor-specific side channels that a plain AHB-style shared bus has no signals for. A peripheral interrupt request is passed to the processor's interrupt input, and the processor's acknowledge strobe is returned to the peripheral. The processor acknowledges in two low pulses. During the second pulse the block overrides the external address decoder, so that the interrupting peripheral is selected. Its 8-bit vector then reaches the processor's read data bus on the low byte.

The block also handles the hold / hold-acknowledge handover to a DMA engine. A DMA request raises the processor's hold line, and the line stays high until the engine reports completion. Once the processor acknowledges the hold, the master multiplexer passes the bus to the DMA engine. The switch waits for a point where the current owner shows an IDLE transfer, so no transfer is split between masters. While the processor owns the bus, the DMA engine is an ordinary slave that the processor programs through its select line.

Top module: `bus_sideband_ext`

## Requirements
- R1: `cpuIntr` equals the value `perIrq` had at the previous rising clock edge.
- R2: `perAck` is high exactly while `cpuIntaN` (active low) is low.
- R3: Falling edges of `cpuIntaN` are counted per acknowledge sequence. The vector override is active only during the second low pulse: from the cycle after its falling edge is sampled until `cpuIntaN` returns high. It is never active in the first pulse.
- R4: While the override is active, `hselOut` is one-hot with only bit `IRQ_SLOT` (default 2) set, whatever `hselIn` is. Otherwise `hselOut` equals `hselIn`.
- R5: While the override is active, `cpuRdata` carries `perVector` in bits 7:0 and zeros above. Otherwise `cpuRdata` equals `hrdata`.
- R6: Once the rising edge that ends the second pulse is sampled, the sequence restarts, and the next low pulse counts as a first pulse.
- R7: If `cpuIntaN` is sampled high on `GAP_LIMIT` (default 8) consecutive edges after the first pulse, the sequence is abandoned and the next pulse counts as a first pulse. With one high sample fewer, the next pulse still counts as the second.
- R8: `cpuHold` rises on the edge that samples `dmaReq` high. It then stays high, even if `dmaReq` drops, until an edge samples `dmaDone` high; that edge clears it.
- R9: Ownership moves to the DMA engine only on an edge that samples `cpuHlda` high with `cpuHtrans` equal to IDLE (2'b00). Until then, `mHaddr`, `mHtrans`, `mHwrite` and `mHwdata` carry the processor's signals.
- R10: Ownership returns to the processor only on an edge that samples `cpuHlda` low with `dmaHtrans` equal to IDLE (2'b00).
- R11: `dmaGrant` is high exactly while the DMA engine owns the bus. `dmaSlvSel` follows `hselOut[DMA_SLOT]` (default slot 3) while the processor owns the bus and is 0 while the DMA engine owns it.
- R12: After reset, `cpuIntr` and `cpuHold` are 0, the processor owns the bus and no override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| perIrq | input | 1 | Interrupt request from the peripheral |
| cpuIntr | output | 1 | Interrupt request to the processor |
| cpuIntaN | input | 1 | Interrupt acknowledge from the processor, active low |
| perAck | output | 1 | Acknowledge forwarded to the peripheral, active high |
| perVector | input | 8 | Vector number supplied by the interrupting peripheral |
| hselIn | input | SLV_N (4) | Slave selects from the address decoder |
| hselOut | output | SLV_N (4) | Slave selects after the override |
| hrdata | input | DATA_W (16) | Read data from the slave multiplexer |
| cpuRdata | output | DATA_W (16) | Read data to the processor bridge |
| cpuHaddr | input | ADDR_W (20) | Processor bridge address |
| cpuHtrans | input | 2 | Processor bridge transfer type |
| cpuHwrite | input | 1 | Processor bridge write flag |
| cpuHwdata | input | DATA_W (16) | Processor bridge write data |
| dmaHaddr | input | ADDR_W (20) | DMA engine address |
| dmaHtrans | input | 2 | DMA engine transfer type |
| dmaHwrite | input | 1 | DMA engine write flag |
| dmaHwdata | input | DATA_W (16) | DMA engine write data |
| mHaddr | output | ADDR_W (20) | Bus address from the owning master |
| mHtrans | output | 2 | Bus transfer type from the owning master |
| mHwrite | output | 1 | Bus write flag from the owning master |
| mHwdata | output | DATA_W (16) | Bus write data from the owning master |
| dmaReq | input | 1 | DMA engine asks for the bus |
| dmaDone | input | 1 | DMA engine has finished |
| cpuHold | output | 1 | Hold request to the processor |
| cpuHlda | input | 1 | Hold acknowledge from the processor |
| dmaGrant | output | 1 | DMA engine owns the bus |
| dmaSlvSel | output | 1 | Slave select for the DMA configuration registers |

## Verification
A pulse counter that has slipped by one shows at the ports within a single acknowledge pulse. Either the vector override appears in the first pulse, or the second pulse gets no override, and `hselOut` and `cpuRdata` show the fault in the cycle after the falling edge is sampled. A gap timer that is off by one only shows at the exact boundary, so the bench runs gaps of `GAP_LIMIT-1` and `GAP_LIMIT` high samples. An ownership flop that ignores the idle condition puts the wrong master's address on `mHaddr` one edge early, so every handover is checked with a busy transfer held first.

// File: rtl/sbext_pkg.sv
package sbext_pkg;

  localparam logic [1:0] TRANS_IDLE = 2'b00;

  typedef enum logic {
    OWNER_CPU = 1'b0,
    OWNER_DMA = 1'b1
  } owner_e;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_ONE  = 2'd1,
    ACK_TWO  = 2'd2
  } ackPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic vecOverride;
    logic dmaOwns;
  } sbStrobe_t;

endpackage

// File: rtl/sb_control.sv
module sb_control
  import sbext_pkg::*;
#(
  parameter int GAP_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       perIrq,
  input  logic       cpuIntaN,
  input  logic       dmaReq,
  input  logic       dmaDone,
  input  logic       cpuHlda,
  input  logic [1:0] cpuHtrans,
  input  logic [1:0] dmaHtrans,
  output logic       cpuIntr,
  output logic       cpuHold,
  output sbStrobe_t  strb
);

  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LIMIT - 1);

  logic             intaPrev;
  logic             intaFall;
  logic             intaRise;
  ackPhase_e        phase;
  logic [GAP_W-1:0] gapCnt;
  owner_e           owner;
  logic             cpuIdle;
  logic             dmaIdle;

  assign intaFall = intaPrev & ~cpuIntaN;
  assign intaRise = ~intaPrev & cpuIntaN;
  assign cpuIdle  = (cpuHtrans == TRANS_IDLE);
  assign dmaIdle  = (dmaHtrans == TRANS_IDLE);

  // interrupt request path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIntr <= 1'b0;
    else       cpuIntr <= perIrq;
  end

  // acknowledge pulse sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intaPrev <= 1'b1;
      phase    <= ACK_NONE;
      gapCnt   <= '0;
    end else begin
      intaPrev <= cpuIntaN;
      unique case (phase)
        ACK_NONE: if (intaFall) phase <= ACK_ONE;
        ACK_ONE: begin
          if (intaFall)                            phase <= ACK_TWO;
          else if (cpuIntaN && gapCnt == GAP_LAST) phase <= ACK_NONE;
        end
        ACK_TWO:  if (intaRise) phase <= ACK_NONE;
        default:  phase <= ACK_NONE;
      endcase
      if (phase == ACK_ONE && cpuIntaN) gapCnt <= gapCnt + 1'b1;
      else                              gapCnt <= '0;
    end
  end

  assign strb.vecOverride = (phase == ACK_TWO) & ~cpuIntaN;

  // hold request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cpuHold <= 1'b0;
    else if (dmaDone) cpuHold <= 1'b0;
    else if (dmaReq)  cpuHold <= 1'b1;
  end

  // bus ownership, changes only at idle points
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWNER_CPU;
    else begin
      unique case (owner)
        OWNER_CPU: if (cpuHlda && cpuIdle)  owner <= OWNER_DMA;
        OWNER_DMA: if (!cpuHlda && dmaIdle) owner <= OWNER_CPU;
        default:   owner <= OWNER_CPU;
      endcase
    end
  end

  assign strb.dmaOwns = (owner == OWNER_DMA);

  p_intr_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cpuIntr == $past(perIrq));

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuHold && !dmaDone) |=> cpuHold);

  p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> !cpuHold);

  p_to_dma_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.dmaOwns) |-> ($past(cpuHtrans) == TRANS_IDLE && $past(cpuHlda)));

  p_to_cpu_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.dmaOwns) |-> ($past(dmaHtrans) == TRANS_IDLE && !$past(cpuHlda)));

  p_override_after_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.vecOverride) |-> !$past(cpuIntaN));

endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sbext_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int VEC_W    = 8,
  parameter int SLV_N    = 4,
  parameter int IRQ_SLOT = 2,
  parameter int DMA_SLOT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strb,
  input  logic [SLV_N-1:0]  hselIn,
  output logic [SLV_N-1:0]  hselOut,
  input  logic [DATA_W-1:0] hrdata,
  input  logic [VEC_W-1:0]  perVector,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [ADDR_W-1:0] cpuHaddr,
  input  logic [1:0]        cpuHtrans,
  input  logic              cpuHwrite,
  input  logic [DATA_W-1:0] cpuHwdata,
  input  logic [ADDR_W-1:0] dmaHaddr,
  input  logic [1:0]        dmaHtrans,
  input  logic              dmaHwrite,
  input  logic [DATA_W-1:0] dmaHwdata,
  output logic [ADDR_W-1:0] mHaddr,
  output logic [1:0]        mHtrans,
  output logic              mHwrite,
  output logic [DATA_W-1:0] mHwdata,
  output logic              dmaSlvSel
);

  localparam int PAD_W = DATA_W - VEC_W;

  // decoder override, one select line per slot
  for (genvar g = 0; g < SLV_N; g++) begin : g_sel
    if (g == IRQ_SLOT) begin : g_irq
      assign hselOut[g] = strb.vecOverride | hselIn[g];
    end else begin : g_other
      assign hselOut[g] = ~strb.vecOverride & hselIn[g];
    end
  end

  // vector steering onto the low byte
  assign cpuRdata = strb.vecOverride ? {{PAD_W{1'b0}}, perVector} : hrdata;

  // master multiplexer
  always_comb begin
    if (strb.dmaOwns) begin
      mHaddr  = dmaHaddr;
      mHtrans = dmaHtrans;
      mHwrite = dmaHwrite;
      mHwdata = dmaHwdata;
    end else begin
      mHaddr  = cpuHaddr;
      mHtrans = cpuHtrans;
      mHwrite = cpuHwrite;
      mHwdata = cpuHwdata;
    end
  end

  assign dmaSlvSel = hselOut[DMA_SLOT] & ~strb.dmaOwns;

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hselIn) |-> $onehot0(hselOut));

  p_slave_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.dmaOwns |-> !dmaSlvSel);

endmodule

// File: rtl/bus_sideband_ext.sv
module bus_sideband_ext
  import sbext_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SLV_N     = 4,
  parameter int IRQ_SLOT  = 2,
  parameter int DMA_SLOT  = 3,
  parameter int GAP_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              perIrq,
  output logic              cpuIntr,
  input  logic              cpuIntaN,
  output logic              perAck,
  input  logic [7:0]        perVector,
  input  logic [SLV_N-1:0]  hselIn,
  output logic [SLV_N-1:0]  hselOut,
  input  logic [DATA_W-1:0] hrdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [ADDR_W-1:0] cpuHaddr,
  input  logic [1:0]        cpuHtrans,
  input  logic              cpuHwrite,
  input  logic [DATA_W-1:0] cpuHwdata,
  input  logic [ADDR_W-1:0] dmaHaddr,
  input  logic [1:0]        dmaHtrans,
  input  logic              dmaHwrite,
  input  logic [DATA_W-1:0] dmaHwdata,
  output logic [ADDR_W-1:0] mHaddr,
  output logic [1:0]        mHtrans,
  output logic              mHwrite,
  output logic [DATA_W-1:0] mHwdata,
  input  logic              dmaReq,
  input  logic              dmaDone,
  output logic              cpuHold,
  input  logic              cpuHlda,
  output logic              dmaGrant,
  output logic              dmaSlvSel
);

  sbStrobe_t strb;

  assign perAck   = ~cpuIntaN;
  assign dmaGrant = strb.dmaOwns;

  sb_control #(.GAP_LIMIT(GAP_LIMIT)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .perIrq   (perIrq),
    .cpuIntaN (cpuIntaN),
    .dmaReq   (dmaReq),
    .dmaDone  (dmaDone),
    .cpuHlda  (cpuHlda),
    .cpuHtrans(cpuHtrans),
    .dmaHtrans(dmaHtrans),
    .cpuIntr  (cpuIntr),
    .cpuHold  (cpuHold),
    .strb     (strb)
  );

  sb_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .VEC_W   (8),
    .SLV_N   (SLV_N),
    .IRQ_SLOT(IRQ_SLOT),
    .DMA_SLOT(DMA_SLOT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hselIn   (hselIn),
    .hselOut  (hselOut),
    .hrdata   (hrdata),
    .perVector(perVector),
    .cpuRdata (cpuRdata),
    .cpuHaddr (cpuHaddr),
    .cpuHtrans(cpuHtrans),
    .cpuHwrite(cpuHwrite),
    .cpuHwdata(cpuHwdata),
    .dmaHaddr (dmaHaddr),
    .dmaHtrans(dmaHtrans),
    .dmaHwrite(dmaHwrite),
    .dmaHwdata(dmaHwdata),
    .mHaddr   (mHaddr),
    .mHtrans  (mHtrans),
    .mHwrite  (mHwrite),
    .mHwdata  (mHwdata),
    .dmaSlvSel(dmaSlvSel)
  );

  p_ack_forward_r2: assert property (@(posedge clk) disable iff (!rstN)
    perAck != cpuIntaN);

endmodule

// File: tb/test_bus_sideband_ext.sv
module test_bus_sideband_ext;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        perIrq = 1'b0;
  logic        cpuIntr;
  logic        cpuIntaN = 1'b1;
  logic        perAck;
  logic [7:0]  perVector = 8'hA5;
  logic [3:0]  hselIn = 4'b0001;
  logic [3:0]  hselOut;
  logic [15:0] hrdata = 16'h1234;
  logic [15:0] cpuRdata;
  logic [19:0] cpuHaddr = 20'h12345;
  logic [1:0]  cpuHtrans = 2'b00;
  logic        cpuHwrite = 1'b1;
  logic [15:0] cpuHwdata = 16'hC0DE;
  logic [19:0] dmaHaddr = 20'h0ABCD;
  logic [1:0]  dmaHtrans = 2'b00;
  logic        dmaHwrite = 1'b0;
  logic [15:0] dmaHwdata = 16'hD00D;
  logic [19:0] mHaddr;
  logic [1:0]  mHtrans;
  logic        mHwrite;
  logic [15:0] mHwdata;
  logic        dmaReq = 1'b0;
  logic        dmaDone = 1'b0;
  logic        cpuHold;
  logic        cpuHlda = 1'b0;
  logic        dmaGrant;
  logic        dmaSlvSel;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sideband_ext #(.GAP_LIMIT(GAP)) i_bus_sideband_ext (
    .clk(clk), .rstN(rstN), .perIrq(perIrq), .cpuIntr(cpuIntr),
    .cpuIntaN(cpuIntaN), .perAck(perAck), .perVector(perVector),
    .hselIn(hselIn), .hselOut(hselOut), .hrdata(hrdata), .cpuRdata(cpuRdata),
    .cpuHaddr(cpuHaddr), .cpuHtrans(cpuHtrans), .cpuHwrite(cpuHwrite),
    .cpuHwdata(cpuHwdata), .dmaHaddr(dmaHaddr), .dmaHtrans(dmaHtrans),
    .dmaHwrite(dmaHwrite), .dmaHwdata(dmaHwdata), .mHaddr(mHaddr),
    .mHtrans(mHtrans), .mHwrite(mHwrite), .mHwdata(mHwdata),
    .dmaReq(dmaReq), .dmaDone(dmaDone), .cpuHold(cpuHold),
    .cpuHlda(cpuHlda), .dmaGrant(dmaGrant), .dmaSlvSel(dmaSlvSel)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one rising edge, then settle away from it
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic t_reset;
    step(2);
    chk(32'(cpuIntr), 0, "R12 intr in reset");
    chk(32'(cpuHold), 0, "R12 hold in reset");
    chk(32'(dmaGrant), 0, "R12 owner in reset");
    chk(32'(hselOut), 32'h1, "R12 no override in reset");
    rstN = 1'b1;
    step();
    chk(32'(mHaddr), 32'h12345, "R12 cpu owns after reset");
  endtask

  task automatic t_irq;
    perIrq = 1'b1;
    #1 chk(32'(cpuIntr), 0, "R1 not before edge");
    step();
    chk(32'(cpuIntr), 1, "R1 rise after edge");
    perIrq = 1'b0;
    step();
    chk(32'(cpuIntr), 0, "R1 fall after edge");
  endtask

  // one low pulse of given length, then gapHigh high samples
  task automatic pulse(input int lowLen, input int gapHigh);
    cpuIntaN = 1'b0;
    step(lowLen);
    cpuIntaN = 1'b1;
    step(gapHigh);
  endtask

  task automatic t_ack_pair;
    cpuIntaN = 1'b0;
    #1 chk(32'(perAck), 1, "R2 ack low");
    step();
    chk(32'(hselOut), 32'h1, "R3 no override first pulse");
    chk(32'(cpuRdata), 32'h1234, "R5 data passes first pulse");
    step();
    cpuIntaN = 1'b1;
    #1 chk(32'(perAck), 0, "R2 ack high");
    step(3);
    cpuIntaN = 1'b0;
    #1 chk(32'(hselOut), 32'h1, "R3 not before fall sampled");
    step();
    chk(32'(hselOut), 32'h4, "R4 irq slot selected");
    chk(32'(cpuRdata), 32'h00A5, "R5 vector on low byte");
    hselIn = 4'b1010;
    #1 chk(32'(hselOut), 32'h4, "R4 decoder ignored");
    step();
    chk(32'(hselOut), 32'h4, "R3 held through pulse");
    cpuIntaN = 1'b1;
    #1 chk(32'(hselOut), 32'hA, "R3 ends with pulse");
    step();
    hselIn = 4'b0001;
    // restart: next pulse is a first pulse
    cpuIntaN = 1'b0;
    step();
    chk(32'(hselOut), 32'h1, "R6 restart is first pulse");
    chk(32'(cpuRdata), 32'h1234, "R6 no vector after restart");
    cpuIntaN = 1'b1;
    step(GAP);
  endtask

  task automatic t_gap;
    // GAP high samples abandon the sequence
    pulse(2, GAP);
    cpuIntaN = 1'b0;
    step();
    chk(32'(hselOut), 32'h1, "R7 timeout makes first pulse");
    cpuIntaN = 1'b1;
    step(GAP - 1);
    // GAP-1 high samples keep it
    cpuIntaN = 1'b0;
    step();
    chk(32'(hselOut), 32'h4, "R7 boundary still second");
    cpuIntaN = 1'b1;
    step();
  endtask

  task automatic t_hold;
    dmaReq = 1'b1;
    #1 chk(32'(cpuHold), 0, "R8 hold not before edge");
    step();
    chk(32'(cpuHold), 1, "R8 hold raised");
    dmaReq = 1'b0;
    step(3);
    chk(32'(cpuHold), 1, "R8 hold kept");
    dmaDone = 1'b1;
    step();
    chk(32'(cpuHold), 0, "R8 hold cleared");
    dmaDone = 1'b0;
  endtask

  task automatic t_owner;
    hselIn = 4'b1000;
    #1 chk(32'(dmaSlvSel), 1, "R11 slave select cpu owner");
    cpuHtrans = 2'b10;
    dmaHtrans = 2'b10;
    cpuHlda   = 1'b1;
    step(2);
    chk(32'(dmaGrant), 0, "R9 busy cpu keeps bus");
    chk(32'(mHaddr), 32'h12345, "R9 cpu address");
    chk(32'(mHwdata), 32'hC0DE, "R9 cpu data");
    cpuHtrans = 2'b00;
    step();
    chk(32'(dmaGrant), 1, "R9 switch at idle");
    chk(32'(mHaddr), 32'h0ABCD, "R9 dma address");
    chk(32'(mHtrans), 32'h2, "R9 dma trans");
    chk(32'(mHwrite), 0, "R9 dma write flag");
    chk(32'(dmaSlvSel), 0, "R11 slave select off");
    cpuHlda = 1'b0;
    step(2);
    chk(32'(dmaGrant), 1, "R10 busy dma keeps bus");
    dmaHtrans = 2'b00;
    step();
    chk(32'(dmaGrant), 0, "R10 return at idle");
    chk(32'(mHaddr), 32'h12345, "R10 cpu address back");
    chk(32'(dmaSlvSel), 1, "R11 slave select back");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_irq();
    t_ack_pair();
    t_gap();
    t_hold();
    t_owner();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule